// File: doc/BRIEF.md
# Half-Precision to 16-bit Integer Converter

This block converts IEEE 754 half-precision values into 16-bit integers, signed or unsigned, across a 128-bit vector of eight 16-bit lanes. A 7-bit operation code selects the signedness and one of five rounding rules: nearest with ties to even, nearest with ties away from zero, toward minus infinity, toward plus infinity, and toward zero. A full-width flag selects eight lanes or four. A scalar flag restricts the work to lane 0.

Each accepted operation is decoded and converted in one combinational pass. The result is captured in a single register stage, so it appears one cycle after the request. Two sticky exception flags record any invalid conversion and any inexact conversion seen since reset. Values that are out of range saturate. NaNs give zero.

Top module: `fp16_int_conv`

## Requirements
- R1: Signed conversion uses opcode 0x1a for nearest-even, 0x1b for toward minus infinity, 0x1c for nearest with ties away from zero, 0x3a for toward plus infinity, and 0x3b for toward zero.
- R2: Unsigned conversion uses opcode 0x5a for nearest-even, 0x5b for toward minus infinity, 0x5c for ties away, 0x7a for toward plus infinity, and 0x7b for toward zero.
- R3: A NaN input gives lane result 0 and raises invalid. This applies to every NaN encoding (exponent field bits 14:10 all ones, fraction bits 9:0 nonzero).
- R4: A rounded value outside the target range, or an infinity, saturates and raises invalid. Signed results saturate to 0x8000 or 0x7fff. Unsigned results saturate to 0x0000 or 0xffff.
- R5: Under unsigned conversion, a negative input that rounds to a nonzero magnitude gives 0 and raises invalid. A negative input that rounds to zero gives 0 and raises only inexact.
- R6: A finite in-range input that is not an integer raises inexact. An exact integer input raises no flag. Subnormal inputs follow the same rounding rules.
- R7: Lane i occupies result bits 16i+15:16i. With the full-width flag set, all eight lanes convert. With it clear, lanes 0 to 3 convert and bits 127:64 are zero.
- R8: In scalar mode only lane 0 converts, and bits 127:16 of the result are zero.
- R9: Any other opcode gives an all-zero result and leaves both flags unchanged.
- R10: The output valid is high exactly one cycle after each request. Without a request, the result holds its value.
- R11: The exception flags are sticky. They only rise, and reset clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Conversion request |
| opcode | input | 7 | Operation code selecting signedness and rounding |
| isQ | input | 1 | Full-width (eight-lane) vector mode |
| isScalar | input | 1 | Convert lane 0 only |
| operand | input | 128 | Eight half-precision lanes |
| outValid | output | 1 | Result valid, one cycle after the request |
| result | output | 128 | Eight 16-bit integer lanes |
| stickyInvalid | output | 1 | Accumulated invalid flag |
| stickyInexact | output | 1 | Accumulated inexact flag |

## Verification
The hardest cases to reach are the exact rounding boundaries. These include halfway points near the saturation limits, negative fractions under unsigned conversion, and subnormals under directed rounding. Each of these sits at a single encoding among 65536. The bench therefore sweeps every half-precision encoding through all ten opcodes, packing eight consecutive encodings into one request. It compares each lane against a reference built on real-number floor and ceiling arithmetic. Directed requests surrounded by resets isolate the individual flag behaviour. These cover exact values, negative fractions that round to zero, NaN, infinity and unknown opcodes.

// File: rtl/fcvt_pkg.sv
package fcvt_pkg;
  localparam int LANES     = 8;
  localparam int HALF_W    = 16;
  localparam int EXP_W     = 5;
  localparam int MAN_W     = 10;
  localparam int SIG_W     = MAN_W + 1;
  localparam int BIAS      = 2 ** (EXP_W - 1) - 1;
  localparam int FRAC_BITS = BIAS + MAN_W;
  localparam int MAX_EXP   = 2 ** EXP_W - 2;
  localparam int FIX_W     = SIG_W + MAX_EXP;
  localparam int INT_W     = FIX_W - FRAC_BITS;
  localparam int VEC_W     = LANES * HALF_W;
  localparam int OPC_W     = 7;

  typedef enum logic [2:0] {
    RND_EVEN,
    RND_AWAY,
    RND_DOWN,
    RND_UP,
    RND_TRUNC
  } rnd_e;

  typedef struct packed {
    logic             load;
    logic             opOk;
    logic             isSigned;
    rnd_e             rnd;
    logic [LANES-1:0] laneEn;
  } ctrl_t;
endpackage

// File: rtl/fcvt_lane.sv
module fcvt_lane
  import fcvt_pkg::*;
(
  input  logic [HALF_W-1:0] halfIn,
  input  logic              isSigned,
  input  rnd_e              rnd,
  output logic [INT_W-1:0]  laneRes,
  output logic              laneInv,
  output logic              laneInx
);
  localparam logic [INT_W:0] SPOS_MAX = (INT_W+1)'(2 ** (INT_W - 1) - 1);
  localparam logic [INT_W:0] SNEG_MAG = (INT_W+1)'(2 ** (INT_W - 1));
  localparam logic [INT_W:0] UPOS_MAX = (INT_W+1)'(2 ** INT_W - 1);

  logic             sgn;
  logic [EXP_W-1:0] expo;
  logic [MAN_W-1:0] man;
  logic             isNan, isInf;
  logic [EXP_W-1:0] effExp;
  logic [SIG_W-1:0] sig;
  logic [FIX_W-1:0] fixedVal;
  logic [INT_W-1:0] intPart;
  logic             halfBit, restBits, inexactRaw, inc;
  logic [INT_W:0]   rMag;
  logic [INT_W-1:0] negMag;

  always_comb begin
    sgn        = halfIn[HALF_W-1];
    expo       = halfIn[HALF_W-2:MAN_W];
    man        = halfIn[MAN_W-1:0];
    isNan      = (&expo) && (man != '0);
    isInf      = (&expo) && (man == '0);
    effExp     = (expo == '0) ? EXP_W'(1) : expo;
    sig        = {(expo != '0), man};
    // fixed point value scaled by 2^FRAC_BITS
    fixedVal   = {{(FIX_W-SIG_W){1'b0}}, sig} << effExp;
    intPart    = fixedVal[FIX_W-1:FRAC_BITS];
    halfBit    = fixedVal[FRAC_BITS-1];
    restBits   = |fixedVal[FRAC_BITS-2:0];
    inexactRaw = halfBit | restBits;
    case (rnd)
      RND_EVEN: inc = halfBit & (restBits | intPart[0]);
      RND_AWAY: inc = halfBit;
      RND_DOWN: inc = inexactRaw & sgn;
      RND_UP:   inc = inexactRaw & ~sgn;
      default:  inc = 1'b0;
    endcase
    rMag   = {1'b0, intPart} + {{INT_W{1'b0}}, inc};
    negMag = ~rMag[INT_W-1:0] + 1'b1;

    laneRes = '0;
    laneInv = 1'b0;
    laneInx = 1'b0;
    if (isNan) begin
      laneInv = 1'b1;
    end else if (isInf) begin
      laneInv = 1'b1;
      if (isSigned) laneRes = sgn ? SNEG_MAG[INT_W-1:0] : SPOS_MAX[INT_W-1:0];
      else          laneRes = sgn ? '0 : UPOS_MAX[INT_W-1:0];
    end else if (isSigned) begin
      if (!sgn && rMag > SPOS_MAX) begin
        laneInv = 1'b1;
        laneRes = SPOS_MAX[INT_W-1:0];
      end else if (sgn && rMag > SNEG_MAG) begin
        laneInv = 1'b1;
        laneRes = SNEG_MAG[INT_W-1:0];
      end else begin
        laneRes = sgn ? negMag : rMag[INT_W-1:0];
        laneInx = inexactRaw;
      end
    end else begin
      if (sgn && rMag != '0) begin
        laneInv = 1'b1;
      end else if (!sgn && rMag > UPOS_MAX) begin
        laneInv = 1'b1;
        laneRes = UPOS_MAX[INT_W-1:0];
      end else begin
        laneRes = sgn ? '0 : rMag[INT_W-1:0];
        laneInx = inexactRaw;
      end
    end
  end
endmodule

// File: rtl/fcvt_ctrl.sv
module fcvt_ctrl
  import fcvt_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [OPC_W-1:0] opcode,
  input  logic             isQ,
  input  logic             isScalar,
  output ctrl_t            ctrlStb,
  output logic             outValid
);
  always_comb begin
    ctrlStb          = '0;
    ctrlStb.load     = inValid;
    ctrlStb.opOk     = 1'b1;
    ctrlStb.isSigned = ~opcode[6];
    ctrlStb.rnd      = RND_TRUNC;
    case (opcode)
      7'h1a, 7'h5a: ctrlStb.rnd = RND_EVEN;
      7'h1b, 7'h5b: ctrlStb.rnd = RND_DOWN;
      7'h1c, 7'h5c: ctrlStb.rnd = RND_AWAY;
      7'h3a, 7'h7a: ctrlStb.rnd = RND_UP;
      7'h3b, 7'h7b: ctrlStb.rnd = RND_TRUNC;
      default:      ctrlStb.opOk = 1'b0;
    endcase
    for (int i = 0; i < LANES; i++) begin
      if (isScalar)  ctrlStb.laneEn[i] = (i == 0);
      else if (isQ)  ctrlStb.laneEn[i] = 1'b1;
      else           ctrlStb.laneEn[i] = (i < LANES / 2);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end
endmodule

// File: rtl/fcvt_datapath.sv
module fcvt_datapath
  import fcvt_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  ctrl_t            ctrlStb,
  input  logic [VEC_W-1:0] operand,
  output logic [VEC_W-1:0] result,
  output logic             stickyInvalid,
  output logic             stickyInexact
);
  logic [VEC_W-1:0] resNext;
  logic [LANES-1:0] invVec, inxVec;

  for (genvar g = 0; g < LANES; g++) begin : gLane
    logic [INT_W-1:0] laneRes;
    logic             laneInv, laneInx, laneOn;

    fcvt_lane uLane (
      .halfIn   (operand[g*HALF_W +: HALF_W]),
      .isSigned (ctrlStb.isSigned),
      .rnd      (ctrlStb.rnd),
      .laneRes  (laneRes),
      .laneInv  (laneInv),
      .laneInx  (laneInx)
    );

    assign laneOn = ctrlStb.opOk & ctrlStb.laneEn[g];
    assign resNext[g*HALF_W +: HALF_W] = laneOn ? laneRes : '0;
    assign invVec[g] = laneOn & laneInv;
    assign inxVec[g] = laneOn & laneInx;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      result        <= '0;
      stickyInvalid <= 1'b0;
      stickyInexact <= 1'b0;
    end else if (ctrlStb.load) begin
      result        <= resNext;
      stickyInvalid <= stickyInvalid | (|invVec);
      stickyInexact <= stickyInexact | (|inxVec);
    end
  end
endmodule

// File: rtl/fp16_int_conv.sv
module fp16_int_conv
  import fcvt_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [OPC_W-1:0] opcode,
  input  logic             isQ,
  input  logic             isScalar,
  input  logic [VEC_W-1:0] operand,
  output logic             outValid,
  output logic [VEC_W-1:0] result,
  output logic             stickyInvalid,
  output logic             stickyInexact
);
  ctrl_t ctrlStb;

  fcvt_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .opcode   (opcode),
    .isQ      (isQ),
    .isScalar (isScalar),
    .ctrlStb  (ctrlStb),
    .outValid (outValid)
  );

  fcvt_datapath uDp (
    .clk           (clk),
    .rstN          (rstN),
    .ctrlStb       (ctrlStb),
    .operand       (operand),
    .result        (result),
    .stickyInvalid (stickyInvalid),
    .stickyInexact (stickyInexact)
  );
endmodule

// File: rtl/fcvt_chk.sv
module fcvt_chk
  import fcvt_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic [OPC_W-1:0]  opcode,
  input logic              isQ,
  input logic              isScalar,
  input logic [HALF_W-1:0] lane0Half,
  input logic              outValid,
  input logic [VEC_W-1:0]  result,
  input logic              stickyInvalid,
  input logic              stickyInexact
);
  logic knownOp, lane0Nan;
  assign knownOp  = opcode inside {7'h1a, 7'h1b, 7'h1c, 7'h3a, 7'h3b,
                                   7'h5a, 7'h5b, 7'h5c, 7'h7a, 7'h7b};
  assign lane0Nan = (&lane0Half[HALF_W-2:MAN_W]) && (lane0Half[MAN_W-1:0] != '0);

  // R10
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> (!outValid && $stable(result)));
  // R11
  sticky_inv_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$fell(stickyInvalid));
  // R11
  sticky_inx_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$fell(stickyInexact));
  // R7
  half_upper_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !isQ) |=> (result[VEC_W-1:VEC_W/2] == '0));
  // R8
  scalar_upper_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && isScalar) |=> (result[VEC_W-1:HALF_W] == '0));
  // R9
  unknown_op_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !knownOp) |=>
      (result == '0 && $stable(stickyInvalid) && $stable(stickyInexact)));
  // R3
  nan_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && knownOp && lane0Nan) |=>
      (result[HALF_W-1:0] == '0 && stickyInvalid));
endmodule

bind fp16_int_conv fcvt_chk uChk (
  .clk           (clk),
  .rstN          (rstN),
  .inValid       (inValid),
  .opcode        (opcode),
  .isQ           (isQ),
  .isScalar      (isScalar),
  .lane0Half     (operand[15:0]),
  .outValid      (outValid),
  .result        (result),
  .stickyInvalid (stickyInvalid),
  .stickyInexact (stickyInexact)
);

// File: tb/tb_fp16_int_conv.sv
module tb_fp16_int_conv;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         inValid = 1'b0;
  logic [6:0]   opcode = '0;
  logic         isQ = 1'b0;
  logic         isScalar = 1'b0;
  logic [127:0] operand = '0;
  logic         outValid;
  logic [127:0] result;
  logic         stickyInvalid, stickyInexact;

  int  checks = 0;
  int  errors = 0;
  bit  done = 0;
  bit  expInv = 0;
  bit  expInx = 0;

  always #2 clk = ~clk;  // 250 MHz

  fp16_int_conv dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opcode(opcode),
    .isQ(isQ), .isScalar(isScalar), .operand(operand),
    .outValid(outValid), .result(result),
    .stickyInvalid(stickyInvalid), .stickyInexact(stickyInexact)
  );

  task automatic check(input bit ok, input string tag,
                       input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // reference: returns {invalid, inexact, result}
  function automatic logic [17:0] refLane(input logic [15:0] h, input logic [6:0] opc);
    int mode;
    bit uns;
    bit s;
    int e, m, ee, sig;
    real mag, x, r, f, d;
    longint ri, lo, hi;
    case (opc)
      7'h1a: begin mode = 0; uns = 0; end
      7'h1b: begin mode = 1; uns = 0; end
      7'h1c: begin mode = 2; uns = 0; end
      7'h3a: begin mode = 3; uns = 0; end
      7'h3b: begin mode = 4; uns = 0; end
      7'h5a: begin mode = 0; uns = 1; end
      7'h5b: begin mode = 1; uns = 1; end
      7'h5c: begin mode = 2; uns = 1; end
      7'h7a: begin mode = 3; uns = 1; end
      7'h7b: begin mode = 4; uns = 1; end
      default: return 18'd0;
    endcase
    lo = uns ? 0 : -32768;
    hi = uns ? 65535 : 32767;
    s = h[15];
    e = int'(h[14:10]);
    m = int'(h[9:0]);
    if (e == 31) begin
      if (m != 0) return {2'b10, 16'h0000};
      return {2'b10, s ? 16'(lo) : 16'(hi)};
    end
    sig = (e == 0) ? m : 1024 + m;
    ee  = (e == 0) ? 1 : e;
    mag = real'(sig);
    if (ee > 25) for (int k = 0; k < ee - 25; k++) mag = mag * 2.0;
    else         for (int k = 0; k < 25 - ee; k++) mag = mag / 2.0;
    x = s ? -mag : mag;
    case (mode)
      0: begin
        f = $floor(x);
        d = x - f;
        if (d > 0.5)      r = f + 1.0;
        else if (d < 0.5) r = f;
        else              r = ($floor(f / 2.0) * 2.0 == f) ? f : f + 1.0;
      end
      1: r = $floor(x);
      2: r = s ? -$floor(mag + 0.5) : $floor(mag + 0.5);
      3: r = $ceil(x);
      default: r = s ? -$floor(mag) : $floor(mag);
    endcase
    ri = longint'(r);
    if (ri < lo) return {2'b10, 16'(lo)};
    if (ri > hi) return {2'b10, 16'(hi)};
    return {1'b0, (r != x), 16'(ri)};
  endfunction

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    inValid = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    expInv = 0;
    expInx = 0;
    // R11 reset clears flags, R10 reset valid
    check(outValid == 1'b0, "R10 reset valid", 128'(outValid), 128'd0);
    check(result == '0, "R10 reset result", result, 128'd0);
    check({stickyInvalid, stickyInexact} == 2'b00, "R11 reset flags",
          128'({stickyInvalid, stickyInexact}), 128'd0);
  endtask

  // called at a negedge; leaves inValid high
  task automatic runOp(input logic [6:0] opc, input bit q, input bit sc,
                       input logic [127:0] data, input string tag);
    logic [127:0] expRes;
    logic [17:0]  r;
    int nLanes;
    opcode = opc; isQ = q; isScalar = sc; operand = data; inValid = 1'b1;
    nLanes = sc ? 1 : (q ? 8 : 4);
    expRes = '0;
    for (int l = 0; l < nLanes; l++) begin
      r = refLane(data[16*l +: 16], opc);
      expRes[16*l +: 16] = r[15:0];
      expInv |= r[17];
      expInx |= r[16];
    end
    @(negedge clk);
    check(outValid == 1'b1, "R10 valid", 128'(outValid), 128'd1);
    check(result == expRes, tag, result, expRes);
    check({stickyInvalid, stickyInexact} == {expInv, expInx}, {tag, " flags R11"},
          128'({stickyInvalid, stickyInexact}), 128'({expInv, expInx}));
  endtask

  function automatic logic [127:0] fill(input logic [15:0] h);
    return {8{h}};
  endfunction

  initial begin
    logic [6:0]   opList [10];
    logic [127:0] held;
    logic [127:0] vec;
    opList = '{7'h1a, 7'h1b, 7'h1c, 7'h3a, 7'h3b, 7'h5a, 7'h5b, 7'h5c, 7'h7a, 7'h7b};

    doReset();

    // R6 exact integer: 3.0 gives 3, no flags (R1 nearest-even)
    runOp(7'h1a, 1, 0, fill(16'h4200), "R1 R6 exact 3.0");
    // R6 2.5 inexact; R1 ties-even to 2, ties-away to 3, down on -2.5 to -3
    runOp(7'h1a, 1, 0, fill(16'h4100), "R1 R6 2.5 even");
    runOp(7'h1c, 1, 0, fill(16'h4100), "R1 2.5 away");
    runOp(7'h1b, 1, 0, fill(16'hC100), "R1 -2.5 down");
    inValid = 1'b0;

    // R5 negative rounding to zero: inexact only
    doReset();
    runOp(7'h7b, 1, 0, fill(16'hB666), "R5 -0.4 unsigned trunc");
    check(stickyInvalid == 1'b0, "R5 no invalid", 128'(stickyInvalid), 128'd0);
    // R5 negative rounding below zero: invalid
    runOp(7'h5a, 1, 0, fill(16'hB8CD), "R5 -0.6 unsigned even");
    inValid = 1'b0;

    // R4 infinities and large values saturate
    doReset();
    runOp(7'h3b, 1, 0, {fill(16'h7C00)} ^ {64'h0, {4{16'h8000}}}, "R4 inf signed");
    runOp(7'h7a, 1, 0, {4{16'h7C00, 16'hFC00}}, "R4 inf unsigned");
    runOp(7'h1a, 1, 0, fill(16'h7800), "R4 32768 signed");
    inValid = 1'b0;

    // R3 NaN gives zero and invalid
    doReset();
    runOp(7'h5c, 1, 0, {4{16'h7E00, 16'hFC01}}, "R3 NaN");
    check(stickyInvalid == 1'b1, "R3 invalid raised", 128'(stickyInvalid), 128'd1);
    inValid = 1'b0;

    // R7 half width, R8 scalar
    doReset();
    vec = {16'h4200, 16'h4400, 16'h4500, 16'h4600, 16'h4700, 16'h4800, 16'h4880, 16'h3C00};
    runOp(7'h3b, 0, 0, vec, "R7 four lanes");
    runOp(7'h1a, 1, 0, vec, "R7 eight lanes");
    runOp(7'h5a, 0, 1, vec, "R8 scalar");
    runOp(7'h1a, 1, 1, fill(16'hC200), "R8 scalar negative zero-extended");
    inValid = 1'b0;

    // R9 unknown opcodes: zero, flags unchanged
    doReset();
    runOp(7'h1d, 1, 0, fill(16'h7E00), "R9 opcode 0x1d");
    runOp(7'h00, 1, 0, fill(16'h4100), "R9 opcode 0x00");
    runOp(7'h7c, 1, 0, fill(16'hFC00), "R9 opcode 0x7c");
    check({stickyInvalid, stickyInexact} == 2'b00, "R9 flags untouched",
          128'({stickyInvalid, stickyInexact}), 128'd0);

    // R10 hold when idle
    runOp(7'h1a, 1, 0, vec, "R10 load");
    held = result;
    inValid = 1'b0;
    operand = fill(16'h4100);
    @(negedge clk);
    check(outValid == 1'b0, "R10 idle valid", 128'(outValid), 128'd0);
    check(result == held, "R10 idle hold", result, held);

    // exhaustive sweep: R1 R2 opcode map, R3 R4 R5 R6 across all encodings
    doReset();
    for (int oi = 0; oi < 10; oi++) begin
      for (int b = 0; b < 65536; b += 8) begin
        for (int l = 0; l < 8; l++) vec[16*l +: 16] = 16'(b + l);
        runOp(opList[oi], 1, 0, vec, (oi < 5) ? "R1 sweep" : "R2 sweep");
      end
    end
    inValid = 1'b0;
    @(negedge clk);
    check({stickyInvalid, stickyInexact} == 2'b11, "R11 sticky after sweep",
          128'({stickyInvalid, stickyInexact}), 128'd3);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule